// File: doc/BRIEF.md
# Two-window vsync shadow configuration commit

This block keeps two copies of the setup of each of two display windows. Software writes a shadow copy through a plain write/read register port. The display path uses an active copy. The active copy changes only on the vsync pulse, at the moment frame DMA would start. So a frame never scans out with a half-written window description.

A commit has to be armed. Software sets the update bit, and the next vsync copies every window whose protect bit is clear. A protected window keeps its pending request. It is copied at the first vsync after software clears its protect bit. The pending flag for a window clears only when that window has actually been copied. The update bit reads as set while any window is still pending. Disabling a window follows the same path, so scanout of that window stops only at the next vsync.

The active copy holds two values that are computed during the commit. The first is the on-screen bottom-right corner, derived from the top-left corner and the window size. The second is the DMA burst length, derived from the whole buffer width. Only window 1 has a colour-key value.

Top module: `win_shadow_commit`

## Requirements
- R1: After reset, all shadow and active fields are zero, the protect register is zero and no commit is pending.
- R2: A write updates only the shadow copy. Reading a window register returns the shadow value. Active outputs keep their old value until a commit.
- R3: Writing 1 to bit 0 of the update register (address 0x11) arms a commit. Read bit 0 of that register is 1 while any window is pending and returns to 0 once every window has been copied. An arming write in the same cycle as vsync leaves the request pending for the next vsync.
- R4: A vsync with no armed request leaves every active output unchanged.
- R5: Bit w of the protect register (address 0x10) holds back window w at vsync while the other window commits. The held window is copied at the first vsync after its protect bit is cleared.
- R6: Clearing a window's enable bit (bit 0 of window offset 5) changes the active enable only at the next committing vsync.
- R7: The active bottom-right corner is top-left plus size minus one on each axis, and is 0 when top-left plus size is 0. Top-left sits at offset 3 and size at offset 4, with x in bits 15:0 and y in bits 31:16.
- R8: The active burst bit is 1 (16-word bursts) when the whole width is 128 or more, and 0 (8-word bursts) when it is 127 or less. Whole width is bits 15:0 of offset 1.
- R9: Only window 1 has a colour key (offset 6). On window 0 that offset reads 0, and a write to it changes nothing.
- R10: Bits 3:2 of the update register show the per-window pending flags, window 0 in bit 2. A flag clears only at a vsync that copies that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address: {global, window, offset[2:0]} |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| vsync_i | input | 1 | Frame start pulse, one cycle |
| act_en_o | output | 2 | Active window enables |
| act_burst16_o | output | 2 | Active burst select (1 = 16-word) |
| act_base_o | output | 64 | Active buffer start address per window |
| act_full_w_o | output | 32 | Active whole buffer width per window |
| act_full_h_o | output | 32 | Active whole buffer height per window |
| act_off_x_o | output | 32 | Active source x offset per window |
| act_off_y_o | output | 32 | Active source y offset per window |
| act_tl_x_o | output | 32 | Active top-left x per window |
| act_tl_y_o | output | 32 | Active top-left y per window |
| act_br_x_o | output | 32 | Active bottom-right x per window |
| act_br_y_o | output | 32 | Active bottom-right y per window |
| act_key_o | output | 32 | Active colour key of window 1 |

## Verification
The hardest case to reach is a protected window whose request outlives several vsyncs while the other window commits on the first one. In that state the update bit still reads set, only one pending flag remains, and the held window's active fields must not move. The stimulus arms an update with window 0 protected and runs two vsyncs. It then clears the protect bit and checks that the active copy is still unchanged. Only after the next vsync does it check for the new values. A separate test strikes the arming write and vsync in the same clock, to show the request survives that collision.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int OFF_W = 3;
  localparam logic [OFF_W-1:0] OFF_BASE = 3'd0;
  localparam logic [OFF_W-1:0] OFF_FULL = 3'd1;
  localparam logic [OFF_W-1:0] OFF_SRC  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_TL   = 3'd3;
  localparam logic [OFF_W-1:0] OFF_SIZE = 3'd4;
  localparam logic [OFF_W-1:0] OFF_CTRL = 3'd5;
  localparam logic [OFF_W-1:0] OFF_KEY  = 3'd6;
  localparam logic [OFF_W-1:0] GOFF_PROT = 3'd0;
  localparam logic [OFF_W-1:0] GOFF_UPD  = 3'd1;
endpackage

// File: rtl/wsc_commit_ctl.sv
module wsc_commit_ctl #(
  parameter int NUM_WIN = 2,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prot_wr_i,
  input  logic               upd_wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               vsync_i,
  output logic [NUM_WIN-1:0] prot_o,
  output logic [NUM_WIN-1:0] pend_o,
  output logic [NUM_WIN-1:0] commit_o
);
  logic [NUM_WIN-1:0] prot_q, pend_q, pend_d;

  assign commit_o = {NUM_WIN{vsync_i}} & pend_q & ~prot_q;

  always_comb begin
    pend_d = pend_q & ~commit_o;
    if (upd_wr_i && wdata_i[0]) pend_d = '1;  // new request survives a same-cycle vsync
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= '0;
      pend_q <= '0;
    end else begin
      if (prot_wr_i) prot_q <= wdata_i[NUM_WIN-1:0];
      pend_q <= pend_d;
    end
  end

  assign prot_o = prot_q;
  assign pend_o = pend_q;

  assert_arm_sets_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_wr_i && wdata_i[0]) |=> (&pend_q));

  assert_pend_falls_on_vsync_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(pend_q) & ~pend_q)) |-> $past(vsync_i));

  assert_protected_stays_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_q & prot_q) & ~pend_q) == '0));
endmodule

// File: rtl/wsc_win_regs.sv
module wsc_win_regs
  import wsc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DIM_W       = 16,
  parameter int BURST_MIN_W = 128,
  parameter bit HAS_KEY     = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              commit_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              act_en_o,
  output logic              act_burst16_o,
  output logic [DATA_W-1:0] act_base_o,
  output logic [DIM_W-1:0]  act_fw_o,
  output logic [DIM_W-1:0]  act_fh_o,
  output logic [DIM_W-1:0]  act_ox_o,
  output logic [DIM_W-1:0]  act_oy_o,
  output logic [DIM_W-1:0]  act_tlx_o,
  output logic [DIM_W-1:0]  act_tly_o,
  output logic [DIM_W-1:0]  act_brx_o,
  output logic [DIM_W-1:0]  act_bry_o,
  output logic [DATA_W-1:0] act_key_o
);
  localparam logic [DIM_W-1:0] BURST_MIN = DIM_W'(BURST_MIN_W);

  logic [DATA_W-1:0] sh_base, sh_key;
  logic [DIM_W-1:0]  sh_fw, sh_fh, sh_ox, sh_oy, sh_tlx, sh_tly, sh_sw, sh_sh;
  logic              sh_en;

  logic [DATA_W-1:0] a_base;
  logic [DIM_W-1:0]  a_fw, a_fh, a_ox, a_oy, a_tlx, a_tly, a_brx, a_bry;
  logic              a_en, a_burst;

  function automatic logic [DIM_W-1:0] corner(input logic [DIM_W-1:0] tl,
                                              input logic [DIM_W-1:0] sz);
    logic [DIM_W:0] sum;
    sum = {1'b0, tl} + {1'b0, sz};
    corner = (sum == '0) ? '0 : DIM_W'(sum - 1'b1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_base <= '0; sh_fw <= '0; sh_fh <= '0; sh_ox <= '0; sh_oy <= '0;
      sh_tlx <= '0; sh_tly <= '0; sh_sw <= '0; sh_sh <= '0; sh_en <= 1'b0;
    end else if (wr_i) begin
      unique case (off_i)
        OFF_BASE: sh_base <= wdata_i;
        OFF_FULL: begin sh_fw <= wdata_i[DIM_W-1:0]; sh_fh <= wdata_i[2*DIM_W-1:DIM_W]; end
        OFF_SRC:  begin sh_ox <= wdata_i[DIM_W-1:0]; sh_oy <= wdata_i[2*DIM_W-1:DIM_W]; end
        OFF_TL:   begin sh_tlx <= wdata_i[DIM_W-1:0]; sh_tly <= wdata_i[2*DIM_W-1:DIM_W]; end
        OFF_SIZE: begin sh_sw <= wdata_i[DIM_W-1:0]; sh_sh <= wdata_i[2*DIM_W-1:DIM_W]; end
        OFF_CTRL: sh_en <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_base <= '0; a_fw <= '0; a_fh <= '0; a_ox <= '0; a_oy <= '0;
      a_tlx <= '0; a_tly <= '0; a_brx <= '0; a_bry <= '0;
      a_en <= 1'b0; a_burst <= 1'b0;
    end else if (commit_i) begin
      a_base  <= sh_base;
      a_fw    <= sh_fw;
      a_fh    <= sh_fh;
      a_ox    <= sh_ox;
      a_oy    <= sh_oy;
      a_tlx   <= sh_tlx;
      a_tly   <= sh_tly;
      a_brx   <= corner(sh_tlx, sh_sw);
      a_bry   <= corner(sh_tly, sh_sh);
      a_en    <= sh_en;
      a_burst <= (sh_fw >= BURST_MIN);
    end
  end

  generate
    if (HAS_KEY) begin : g_key
      logic [DATA_W-1:0] a_key;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_key <= '0;
        else if (wr_i && off_i == OFF_KEY) sh_key <= wdata_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) a_key <= '0;
        else if (commit_i) a_key <= sh_key;
      end
      assign act_key_o = a_key;
    end else begin : g_nokey
      assign sh_key    = '0;
      assign act_key_o = '0;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    unique case (off_i)
      OFF_BASE: rdata_o = sh_base;
      OFF_FULL: begin rdata_o[DIM_W-1:0] = sh_fw;  rdata_o[2*DIM_W-1:DIM_W] = sh_fh;  end
      OFF_SRC:  begin rdata_o[DIM_W-1:0] = sh_ox;  rdata_o[2*DIM_W-1:DIM_W] = sh_oy;  end
      OFF_TL:   begin rdata_o[DIM_W-1:0] = sh_tlx; rdata_o[2*DIM_W-1:DIM_W] = sh_tly; end
      OFF_SIZE: begin rdata_o[DIM_W-1:0] = sh_sw;  rdata_o[2*DIM_W-1:DIM_W] = sh_sh;  end
      OFF_CTRL: rdata_o[0] = sh_en;
      OFF_KEY:  rdata_o = sh_key;
      default: ;
    endcase
  end

  assign act_en_o      = a_en;
  assign act_burst16_o = a_burst;
  assign act_base_o    = a_base;
  assign act_fw_o      = a_fw;
  assign act_fh_o      = a_fh;
  assign act_ox_o      = a_ox;
  assign act_oy_o      = a_oy;
  assign act_tlx_o     = a_tlx;
  assign act_tly_o     = a_tly;
  assign act_brx_o     = a_brx;
  assign act_bry_o     = a_bry;

  assert_active_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(a_base) && $stable(a_en) && $stable(a_fw) && $stable(a_brx)));

  assert_commit_copies_shadow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (a_base == $past(sh_base) && a_en == $past(sh_en) && a_tlx == $past(sh_tlx)));

  assert_burst_matches_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_burst == (a_fw >= BURST_MIN));
endmodule

// File: rtl/win_shadow_commit.sv
module win_shadow_commit
  import wsc_pkg::*;
#(
  parameter int NUM_WIN     = 2,
  parameter int DATA_W      = 32,
  parameter int DIM_W       = 16,
  parameter int BURST_MIN_W = 128,
  localparam int WIN_BITS   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int AW         = 1 + WIN_BITS + OFF_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic                       vsync_i,
  output logic [NUM_WIN-1:0]         act_en_o,
  output logic [NUM_WIN-1:0]         act_burst16_o,
  output logic [NUM_WIN*DATA_W-1:0]  act_base_o,
  output logic [NUM_WIN*DIM_W-1:0]   act_full_w_o,
  output logic [NUM_WIN*DIM_W-1:0]   act_full_h_o,
  output logic [NUM_WIN*DIM_W-1:0]   act_off_x_o,
  output logic [NUM_WIN*DIM_W-1:0]   act_off_y_o,
  output logic [NUM_WIN*DIM_W-1:0]   act_tl_x_o,
  output logic [NUM_WIN*DIM_W-1:0]   act_tl_y_o,
  output logic [NUM_WIN*DIM_W-1:0]   act_br_x_o,
  output logic [NUM_WIN*DIM_W-1:0]   act_br_y_o,
  output logic [DATA_W-1:0]          act_key_o
);
  logic                glb;
  logic [WIN_BITS-1:0] win_idx;
  logic [OFF_W-1:0]    off;
  logic [NUM_WIN-1:0]  prot, pend, commit;
  logic [DATA_W-1:0]   win_rd [NUM_WIN];
  logic [DATA_W-1:0]   key_w [NUM_WIN];

  assign glb     = addr_i[AW-1];
  assign win_idx = addr_i[OFF_W +: WIN_BITS];
  assign off     = addr_i[OFF_W-1:0];

  wsc_commit_ctl #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prot_wr_i (wr_en_i && glb && off == GOFF_PROT),
    .upd_wr_i  (wr_en_i && glb && off == GOFF_UPD),
    .wdata_i   (wdata_i),
    .vsync_i   (vsync_i),
    .prot_o    (prot),
    .pend_o    (pend),
    .commit_o  (commit)
  );

  generate
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      wsc_win_regs #(
        .DATA_W(DATA_W), .DIM_W(DIM_W), .BURST_MIN_W(BURST_MIN_W), .HAS_KEY(g > 0)
      ) u_win (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_i          (wr_en_i && !glb && win_idx == WIN_BITS'(g)),
        .off_i         (off),
        .wdata_i       (wdata_i),
        .commit_i      (commit[g]),
        .rdata_o       (win_rd[g]),
        .act_en_o      (act_en_o[g]),
        .act_burst16_o (act_burst16_o[g]),
        .act_base_o    (act_base_o[g*DATA_W +: DATA_W]),
        .act_fw_o      (act_full_w_o[g*DIM_W +: DIM_W]),
        .act_fh_o      (act_full_h_o[g*DIM_W +: DIM_W]),
        .act_ox_o      (act_off_x_o[g*DIM_W +: DIM_W]),
        .act_oy_o      (act_off_y_o[g*DIM_W +: DIM_W]),
        .act_tlx_o     (act_tl_x_o[g*DIM_W +: DIM_W]),
        .act_tly_o     (act_tl_y_o[g*DIM_W +: DIM_W]),
        .act_brx_o     (act_br_x_o[g*DIM_W +: DIM_W]),
        .act_bry_o     (act_br_y_o[g*DIM_W +: DIM_W]),
        .act_key_o     (key_w[g])
      );
    end
  endgenerate

  assign act_key_o = key_w[NUM_WIN-1];

  always_comb begin
    rdata_o = '0;
    if (glb) begin
      if (off == GOFF_PROT) rdata_o[NUM_WIN-1:0] = prot;
      else if (off == GOFF_UPD) begin
        rdata_o[0] = |pend;
        rdata_o[2 +: NUM_WIN] = pend;
      end
    end else if (32'(win_idx) < NUM_WIN) begin
      rdata_o = win_rd[win_idx];
    end
  end
endmodule

// File: tb/tb_win_shadow_commit.sv
module tb_win_shadow_commit;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_V = 2'd2, OP_A = 2'd3;
  localparam int NV = 58;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        vsync_i = 1'b0;
  logic [1:0]  act_en_o, act_burst16_o;
  logic [63:0] act_base_o;
  logic [31:0] act_full_w_o, act_full_h_o, act_off_x_o, act_off_y_o;
  logic [31:0] act_tl_x_o, act_tl_y_o, act_br_x_o, act_br_y_o, act_key_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  win_shadow_commit dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .vsync_i(vsync_i),
    .act_en_o(act_en_o), .act_burst16_o(act_burst16_o), .act_base_o(act_base_o),
    .act_full_w_o(act_full_w_o), .act_full_h_o(act_full_h_o),
    .act_off_x_o(act_off_x_o), .act_off_y_o(act_off_y_o),
    .act_tl_x_o(act_tl_x_o), .act_tl_y_o(act_tl_y_o),
    .act_br_x_o(act_br_x_o), .act_br_y_o(act_br_y_o), .act_key_o(act_key_o)
  );

  // {op, requirement, addr, data/expected}
  localparam logic [42:0] VEC [NV] = '{
    {OP_A, 4'd1,  5'h05, 32'h0000_0000},  // R1
    {OP_R, 4'd1,  5'h11, 32'h0000_0000},  // R1
    {OP_W, 4'd0,  5'h00, 32'h1000_0000},
    {OP_W, 4'd0,  5'h01, 32'h0010_0200},
    {OP_W, 4'd0,  5'h03, 32'h0004_0008},
    {OP_W, 4'd0,  5'h04, 32'h0010_0020},
    {OP_W, 4'd0,  5'h05, 32'h0000_0001},
    {OP_R, 4'd2,  5'h00, 32'h1000_0000},  // R2
    {OP_R, 4'd2,  5'h04, 32'h0010_0020},  // R2
    {OP_A, 4'd2,  5'h00, 32'h0000_0000},  // R2
    {OP_V, 4'd0,  5'h00, 32'h0},
    {OP_A, 4'd4,  5'h00, 32'h0000_0000},  // R4
    {OP_A, 4'd4,  5'h05, 32'h0000_0000},  // R4
    {OP_W, 4'd0,  5'h11, 32'h0000_0001},
    {OP_R, 4'd10, 5'h11, 32'h0000_000D},  // R10
    {OP_V, 4'd0,  5'h00, 32'h0},
    {OP_A, 4'd3,  5'h00, 32'h1000_0000},  // R3
    {OP_A, 4'd8,  5'h05, 32'h0000_0003},  // R8
    {OP_A, 4'd7,  5'h04, 32'h0013_0027},  // R7
    {OP_R, 4'd3,  5'h11, 32'h0000_0000},  // R3
    {OP_W, 4'd0,  5'h10, 32'h0000_0001},
    {OP_W, 4'd0,  5'h00, 32'h2000_0000},
    {OP_W, 4'd0,  5'h08, 32'h3000_0000},
    {OP_W, 4'd0,  5'h09, 32'h0001_0040},
    {OP_W, 4'd0,  5'h0D, 32'h0000_0001},
    {OP_W, 4'd0,  5'h11, 32'h0000_0001},
    {OP_V, 4'd0,  5'h00, 32'h0},
    {OP_A, 4'd5,  5'h00, 32'h1000_0000},  // R5
    {OP_A, 4'd5,  5'h08, 32'h3000_0000},  // R5
    {OP_A, 4'd8,  5'h0D, 32'h0000_0001},  // R8
    {OP_R, 4'd10, 5'h11, 32'h0000_0005},  // R10
    {OP_V, 4'd0,  5'h00, 32'h0},
    {OP_A, 4'd5,  5'h00, 32'h1000_0000},  // R5
    {OP_W, 4'd0,  5'h10, 32'h0000_0000},
    {OP_A, 4'd5,  5'h00, 32'h1000_0000},  // R5
    {OP_V, 4'd0,  5'h00, 32'h0},
    {OP_A, 4'd5,  5'h00, 32'h2000_0000},  // R5
    {OP_R, 4'd10, 5'h11, 32'h0000_0000},  // R10
    {OP_W, 4'd0,  5'h05, 32'h0000_0000},
    {OP_A, 4'd6,  5'h05, 32'h0000_0003},  // R6
    {OP_W, 4'd0,  5'h11, 32'h0000_0001},
    {OP_A, 4'd6,  5'h05, 32'h0000_0003},  // R6
    {OP_V, 4'd0,  5'h00, 32'h0},
    {OP_A, 4'd6,  5'h05, 32'h0000_0002},  // R6
    {OP_W, 4'd0,  5'h0B, 32'h0000_0005},
    {OP_W, 4'd0,  5'h0C, 32'h0000_0003},
    {OP_W, 4'd0,  5'h06, 32'hDEAD_BEEF},
    {OP_R, 4'd9,  5'h06, 32'h0000_0000},  // R9
    {OP_W, 4'd0,  5'h0E, 32'h00FF_00FF},
    {OP_W, 4'd0,  5'h11, 32'h0000_0001},
    {OP_V, 4'd0,  5'h00, 32'h0},
    {OP_A, 4'd7,  5'h0C, 32'h0000_0007},  // R7
    {OP_A, 4'd9,  5'h0E, 32'h00FF_00FF},  // R9
    {OP_A, 4'd9,  5'h00, 32'h2000_0000},  // R9
    {OP_W, 4'd0,  5'h09, 32'h0001_007F},
    {OP_W, 4'd0,  5'h0A, 32'h0005_0006},
    {OP_W, 4'd0,  5'h11, 32'h0000_0001},
    {OP_V, 4'd0,  5'h00, 32'h0}
  };

  function automatic logic [31:0] act_view(input logic [4:0] a);
    int w;
    w = a[3] ? 1 : 0;
    case (a[2:0])
      3'd0: act_view = act_base_o[w*32 +: 32];
      3'd1: act_view = {act_full_h_o[w*16 +: 16], act_full_w_o[w*16 +: 16]};
      3'd2: act_view = {act_off_y_o[w*16 +: 16], act_off_x_o[w*16 +: 16]};
      3'd3: act_view = {act_tl_y_o[w*16 +: 16], act_tl_x_o[w*16 +: 16]};
      3'd4: act_view = {act_br_y_o[w*16 +: 16], act_br_x_o[w*16 +: 16]};
      3'd5: act_view = {30'd0, act_burst16_o[w], act_en_o[w]};
      3'd6: act_view = (w == 1) ? act_key_o : 32'd0;
      default: act_view = 32'd0;
    endcase
  endfunction

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic do_vsync();
    vsync_i = 1'b1;
    @(posedge clk); @(negedge clk);
    vsync_i = 1'b0;
  endtask

  task automatic do_read(input int req, input logic [4:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [4:0]  a;
      logic [31:0] d;
      {op, rq, a, d} = VEC[i];
      case (op)
        OP_W: do_write(a, d);
        OP_V: do_vsync();
        OP_R: do_read(int'(rq), a, d);
        default: check(int'(rq), act_view(a), d);
      endcase
    end
    // R8: width 127 selects 8-word bursts; R2 source offset committed
    check(8, act_view(5'h0D), 32'h0000_0001);
    check(2, act_view(5'h0A), 32'h0005_0006);
    do_write(5'h09, 32'h0001_0080);
    do_write(5'h11, 32'h0000_0001);
    do_vsync();
    check(8, act_view(5'h0D), 32'h0000_0003);  // R8 width 128
    // R3: arming write in the same cycle as vsync stays pending
    wr_en_i = 1'b1; addr_i = 5'h11; wdata_i = 32'h1; vsync_i = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0; vsync_i = 1'b0;
    do_read(3, 5'h11, 32'h0000_000D);
    do_vsync();
    do_read(3, 5'h11, 32'h0000_0000);
    // R1: asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    check(1, act_view(5'h00), 32'h0);
    check(1, act_view(5'h0D), 32'h0);
    do_read(1, 5'h00, 32'h0);
    do_read(1, 5'h10, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule